// File: doc/BRIEF.md
# Triggered DMA Channel

One channel of a memory-to-memory copy engine. Software programs a source address, a destination address, a unit count and a control word. It then sets the enable bit. On that enable edge the channel takes working copies of the address and count registers. The copy starts at once, or it waits for a horizontal-blank pulse, a vertical-blank pulse or an audio-FIFO refill request. Each unit is read over a simple request/valid read port and written over a request/acknowledge write port. A unit is a halfword or a word. After each unit the working addresses step up, step down or hold, and the working count drops by one.

When the count runs out, the channel goes idle. Without repeat it also clears its own enable bit, and it can pulse an interrupt. With repeat it stays enabled and waits for its trigger again. On each new trigger it reloads the count, and it can also reload the destination. The parameter `CH_IDX` (0 to 3) selects which address bits are kept and how wide the count is. Only indices 1 and 2 have the audio-FIFO mode.

Top module: `trig_dma_channel`

## Requirements
- R1: Programmed addresses are masked when written. The source keeps 27 bits for index 0 and 28 bits otherwise. The destination keeps 28 bits for index 3 and 27 bits otherwise. Working addresses wrap modulo 2^32.
- R2: The count is 14 bits wide, or 16 bits for index 3. A programmed count of zero means the all-ones maximum for that width (16383 units at index 1).
- R3: A 0-to-1 change of the enable bit loads the working source, destination and count from the programmed registers. A later rewrite of a programmed register does not affect a transfer that is already armed. `blocking_o` is high exactly when the timing field is 00.
- R4: The control word layout is: enable [15], interrupt enable [14], timing [13:12], word size [10], repeat [9], source adjust [8:7], destination adjust [6:5]. Timing 00 starts on the enable edge, 01 waits for `vblank_i`, 10 waits for `hblank_i`, and 11 waits for an audio-FIFO request. A pulse on the wrong trigger has no effect.
- R5: Adjust code 0 increments the address, 1 decrements it and 2 holds it. The step is 4 bytes for word units (control bit 10 set) and 2 bytes for halfword units.
- R6: Source adjust code 3 holds the source. Destination adjust code 3 increments like code 0. On a repeat re-trigger, code 3 also reloads the working destination from the programmed one.
- R7: After the last unit of a transfer without repeat, the enable bit clears and `busy_o` falls. `irq_o` pulses high for exactly one cycle if interrupt enable is set, and stays low if it is clear.
- R8: With repeat set, the enable bit stays set and no interrupt is raised. Each new trigger reloads the working count from the programmed count, and the source address carries on from where it stopped.
- R9: In audio-FIFO mode (index 1 or 2, timing 11), units are words and the destination is held. The word-size bit reads back as set once a request has been accepted.
- R10: An audio-FIFO request starts exactly 4 units, but only when the channel is idle, enabled, in timing 11, with repeat set, and its programmed destination equals `fifo_addr_i`. Any other request is ignored.
- R11: Each unit is one read followed by one write. `rd_req` stays high with a stable address until `rd_valid`. `wr_req` stays high with stable address and data until `wr_ack`. The two requests are never high together, and `wr_data` is the data that was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_we | input | 1 | Write strobe for the programmed source |
| src_wdata | input | ADDR_W | Source address value |
| dst_we | input | 1 | Write strobe for the programmed destination |
| dst_wdata | input | ADDR_W | Destination address value |
| cnt_we | input | 1 | Write strobe for the programmed count |
| cnt_wdata | input | CNT_W | Unit count value (zero = maximum) |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word value |
| ctl_q | output | 16 | Current control word |
| hblank_i | input | 1 | Horizontal-blank trigger pulse |
| vblank_i | input | 1 | Vertical-blank trigger pulse |
| fifo_req_i | input | 1 | Audio-FIFO refill request pulse |
| fifo_addr_i | input | ADDR_W | Address of the requesting FIFO |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_word | output | 1 | Read unit is a word (else halfword) |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | DATA_W | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_word | output | 1 | Write unit is a word (else halfword) |
| wr_data | output | DATA_W | Write data |
| wr_ack | input | 1 | Write acknowledge |
| busy_o | output | 1 | Channel is active |
| blocking_o | output | 1 | Timing field selects immediate start |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
A wrong working address shows on `rd_addr` or `wr_addr` at the very next unit, within three cycles when the bus answers at once. The bench therefore records every write and compares each address, each data word and each size against a model of the stepping rules. A wrong working count shows as an extra or a missing write, and as a completion interrupt in the wrong cycle. A stale enable or a wrong trigger decode shows as `busy_o` rising when it should not, or as `ctl_q` bit 15 holding the wrong value after completion. A reload that was skipped on a repeat re-trigger shows on the first write address of the next burst.

// File: rtl/trig_dma_pkg.sv
package trig_dma_pkg;

   typedef enum logic [1:0] {
      ADJ_INC   = 2'd0,
      ADJ_DEC   = 2'd1,
      ADJ_HOLD  = 2'd2,
      ADJ_INCRL = 2'd3
   } adj_e;

   typedef enum logic [1:0] {
      TM_NOW   = 2'd0,
      TM_VBL   = 2'd1,
      TM_HBL   = 2'd2,
      TM_AUDIO = 2'd3
   } timing_e;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_READ  = 2'd1,
      SEQ_WRITE = 2'd2
   } seq_e;

   // control word, msb first
   typedef struct packed {
      logic       en;
      logic       irq_en;
      logic [1:0] timing;
      logic       spare11;
      logic       word;
      logic       rep;
      logic [1:0] sadj;
      logic [1:0] dadj;
      logic [4:0] spare_lo;
   } ctl_t;

endpackage

// File: rtl/trig_dma_addr_step.sv
module trig_dma_addr_step
   import trig_dma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter bit CODE3_INCR = 1'b0
) (
   input  logic [ADDR_W-1:0] cur,
   input  adj_e              mode,
   input  logic              word,
   output logic [ADDR_W-1:0] nxt
);

   logic [ADDR_W-1:0] stride;
   logic [ADDR_W-1:0] code3_val;

   assign stride = word ? ADDR_W'(4) : ADDR_W'(2);

   generate
      if (CODE3_INCR) begin : g_c3_inc
         assign code3_val = cur + stride;
      end else begin : g_c3_hold
         assign code3_val = cur;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         ADJ_INC:  nxt = cur + stride;
         ADJ_DEC:  nxt = cur - stride;
         ADJ_HOLD: nxt = cur;
         default:  nxt = code3_val;
      endcase
   end

endmodule

// File: rtl/trig_dma_unit_seq.sv
module trig_dma_unit_seq
   import trig_dma_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              wr_ack,
   output logic              rd_req,
   output logic              wr_req,
   output logic [DATA_W-1:0] wr_data,
   output logic              unit_done
);

   seq_e              state_q;
   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         hold_q  <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE:  if (go) state_q <= SEQ_READ;
            SEQ_READ:  if (rd_valid) begin
                          hold_q  <= rd_data;
                          state_q <= SEQ_WRITE;
                       end
            SEQ_WRITE: if (wr_ack) state_q <= SEQ_IDLE;
            default:   state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign rd_req    = (state_q == SEQ_READ);
   assign wr_req    = (state_q == SEQ_WRITE);
   assign wr_data   = hold_q;
   assign unit_done = (state_q == SEQ_WRITE) && wr_ack;

endmodule

// File: rtl/trig_dma_channel.sv
module trig_dma_channel
   import trig_dma_pkg::*;
#(
   parameter  int CH_IDX = 1,
   parameter  int ADDR_W = 32,
   parameter  int DATA_W = 32,
   localparam int CNT_W  = (CH_IDX == 3) ? 16 : 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_we,
   input  logic [ADDR_W-1:0] src_wdata,
   input  logic              dst_we,
   input  logic [ADDR_W-1:0] dst_wdata,
   input  logic              cnt_we,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              ctl_we,
   input  logic [15:0]       ctl_wdata,
   output logic [15:0]       ctl_q,
   input  logic              hblank_i,
   input  logic              vblank_i,
   input  logic              fifo_req_i,
   input  logic [ADDR_W-1:0] fifo_addr_i,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_word,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              wr_word,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ack,
   output logic              busy_o,
   output logic              blocking_o,
   output logic              irq_o
);

   localparam int SRC_KEEP = (CH_IDX == 0) ? 27 : 28;
   localparam int DST_KEEP = (CH_IDX == 3) ? 28 : 27;
   localparam logic [ADDR_W-1:0] SRC_MASK = {{(ADDR_W-SRC_KEEP){1'b0}}, {SRC_KEEP{1'b1}}};
   localparam logic [ADDR_W-1:0] DST_MASK = {{(ADDR_W-DST_KEEP){1'b0}}, {DST_KEEP{1'b1}}};
   localparam bit HAS_FIFO = (CH_IDX == 1) || (CH_IDX == 2);
   localparam logic [CNT_W-1:0] FIFO_UNITS = CNT_W'(4);

   if (CH_IDX < 0 || CH_IDX > 3) begin : g_bad_idx
      $error("trig_dma_channel: CH_IDX must be 0..3");
   end
   if (ADDR_W < 28) begin : g_bad_aw
      $error("trig_dma_channel: ADDR_W must be at least 28");
   end
   if (DATA_W != 32) begin : g_bad_dw
      $error("trig_dma_channel: DATA_W must be 32");
   end

   logic [ADDR_W-1:0] prog_src, prog_dst, work_src, work_dst;
   logic [ADDR_W-1:0] src_nxt, dst_nxt;
   logic [CNT_W-1:0]  prog_cnt, work_cnt, cnt_load;
   ctl_t              ctl_r, ctl_new;
   logic              active_q, irq_q, unit_done;
   logic              audio_mode, unit_word, blank_hit, fifo_hit;
   adj_e              dst_mode;

   assign ctl_new    = ctl_t'(ctl_wdata);
   assign cnt_load   = (prog_cnt == '0) ? '1 : prog_cnt;
   assign audio_mode = HAS_FIFO && (timing_e'(ctl_r.timing) == TM_AUDIO);
   assign unit_word  = audio_mode || ctl_r.word;
   assign dst_mode   = audio_mode ? ADJ_HOLD : adj_e'(ctl_r.dadj);

   assign blank_hit = !active_q && ctl_r.en &&
                      ((vblank_i && timing_e'(ctl_r.timing) == TM_VBL) ||
                       (hblank_i && timing_e'(ctl_r.timing) == TM_HBL));

   generate
      if (HAS_FIFO) begin : g_fifo
         assign fifo_hit = fifo_req_i && !active_q && ctl_r.en && ctl_r.rep &&
                           (timing_e'(ctl_r.timing) == TM_AUDIO) &&
                           (prog_dst == fifo_addr_i);
      end else begin : g_no_fifo
         assign fifo_hit = 1'b0;
      end
   endgenerate

   trig_dma_addr_step #(.ADDR_W(ADDR_W), .CODE3_INCR(1'b0)) u_src_step (
      .cur(work_src), .mode(adj_e'(ctl_r.sadj)), .word(unit_word), .nxt(src_nxt)
   );

   trig_dma_addr_step #(.ADDR_W(ADDR_W), .CODE3_INCR(1'b1)) u_dst_step (
      .cur(work_dst), .mode(dst_mode), .word(unit_word), .nxt(dst_nxt)
   );

   trig_dma_unit_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(active_q),
      .rd_valid(rd_valid), .rd_data(rd_data), .wr_ack(wr_ack),
      .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data), .unit_done(unit_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_src <= '0;
         prog_dst <= '0;
         prog_cnt <= '0;
         work_src <= '0;
         work_dst <= '0;
         work_cnt <= '0;
         ctl_r    <= '0;
         active_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (src_we) prog_src <= src_wdata & SRC_MASK;
         if (dst_we) prog_dst <= dst_wdata & DST_MASK;
         if (cnt_we) prog_cnt <= cnt_wdata;

         if (unit_done) begin
            work_src <= src_nxt;
            work_dst <= dst_nxt;
            work_cnt <= work_cnt - 1'b1;
            if (work_cnt == CNT_W'(1)) begin
               active_q <= 1'b0;
               if (!ctl_r.rep) begin
                  ctl_r.en <= 1'b0;
                  irq_q    <= ctl_r.irq_en;
               end
            end
         end else if (fifo_hit) begin
            work_cnt   <= FIFO_UNITS;
            ctl_r.word <= 1'b1;
            active_q   <= 1'b1;
         end else if (blank_hit) begin
            active_q <= 1'b1;
            if (ctl_r.rep) begin
               work_cnt <= cnt_load;
               if (adj_e'(ctl_r.dadj) == ADJ_INCRL) work_dst <= prog_dst;
            end
         end

         if (ctl_we) begin
            if (!ctl_r.en && ctl_new.en) begin
               work_src <= prog_src;
               work_dst <= prog_dst;
               work_cnt <= cnt_load;
               active_q <= (timing_e'(ctl_new.timing) == TM_NOW);
            end
            ctl_r <= ctl_new;
         end
      end
   end

   assign ctl_q      = ctl_r;
   assign rd_addr    = work_src;
   assign wr_addr    = work_dst;
   assign rd_word    = unit_word;
   assign wr_word    = unit_word;
   assign busy_o     = active_q;
   assign blocking_o = (timing_e'(ctl_r.timing) == TM_NOW);
   assign irq_o      = irq_q;

endmodule

// File: rtl/trig_dma_channel_chk.sv
module trig_dma_channel_chk #(
   parameter int CH_IDX = 1,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_word,
   input logic              wr_req,
   input logic              wr_ack,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_word,
   input logic              busy_o,
   input logic              irq_o,
   input logic [15:0]       ctl_q
);

   localparam bit HAS_FIFO = (CH_IDX == 1) || (CH_IDX == 2);

   // R11: read and write phases never overlap
   p_one_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));

   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

   p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

   // R3: no bus traffic is started while the channel is idle
   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !rd_req);

   // R7: interrupt is a single-cycle pulse coinciding with a cleared enable
   p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   p_irq_clears_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (!ctl_q[15] && !busy_o));

   // R9: audio mode moves whole words
   p_audio_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_FIFO && ctl_q[13:12] == 2'b11 && (rd_req || wr_req)) |-> (rd_word && wr_word));

endmodule

bind trig_dma_channel trig_dma_channel_chk #(
   .CH_IDX(CH_IDX), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_valid(rd_valid), .rd_addr(rd_addr),
   .rd_word(rd_word), .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr),
   .wr_data(wr_data), .wr_word(wr_word), .busy_o(busy_o), .irq_o(irq_o), .ctl_q(ctl_q)
);

// File: tb/trig_dma_channel_bench.sv
module trig_dma_channel_bench;

   localparam int CNT_W = 14;
   localparam logic [31:0] SMASK = 32'h0FFF_FFFF;
   localparam logic [31:0] DMASK = 32'h07FF_FFFF;

   typedef struct packed {
      logic [15:0] ctl;
      logic [31:0] src;
      logic [31:0] dst;
      logic [15:0] cnt;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{16'hC400, 32'h0000_1000, 32'h0200_0000, 16'd3},
      '{16'h8080, 32'h0000_0100, 32'h0000_0300, 16'd4},
      '{16'hC520, 32'h0000_0010, 32'h0000_0400, 16'd2},
      '{16'h81E0, 32'h0000_0020, 32'h0000_0040, 16'd3},
      '{16'h8080, 32'h0000_0002, 32'hFFFF_FFF0, 16'd3},
      '{16'h8400, 32'hF000_0008, 32'h0000_0050, 16'd2}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic src_we = 0, dst_we = 0, cnt_we = 0, ctl_we = 0;
   logic [31:0] src_wdata = 0, dst_wdata = 0;
   logic [CNT_W-1:0] cnt_wdata = 0;
   logic [15:0] ctl_wdata = 0, ctl_q;
   logic hblank_i = 0, vblank_i = 0, fifo_req_i = 0;
   logic [31:0] fifo_addr_i = 0;
   logic rd_req, rd_word, wr_req, wr_word, busy_o, blocking_o, irq_o;
   logic [31:0] rd_addr, wr_addr, wr_data;
   logic rd_valid = 0, wr_ack = 0;
   logic [31:0] rd_data = 0;

   always #5 clk = ~clk;

   trig_dma_channel #(.CH_IDX(1)) u_trig_dma_channel (
      .clk(clk), .rst_n(rst_n),
      .src_we(src_we), .src_wdata(src_wdata), .dst_we(dst_we), .dst_wdata(dst_wdata),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_q(ctl_q), .hblank_i(hblank_i), .vblank_i(vblank_i), .fifo_req_i(fifo_req_i),
      .fifo_addr_i(fifo_addr_i), .rd_req(rd_req), .rd_addr(rd_addr), .rd_word(rd_word),
      .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_word(wr_word), .wr_data(wr_data), .wr_ack(wr_ack), .busy_o(busy_o),
      .blocking_o(blocking_o), .irq_o(irq_o)
   );

   int nvec = 0, nfail = 0;
   int lat = 0, rwait = 0, wwait = 0;
   int nw = 0, nirq = 0;
   logic [31:0] wa [64];
   logic [31:0] wd [64];
   logic        ws [64];
   logic [31:0] last_wa;

   // bus model: read data is the inverted address
   always @(negedge clk) begin
      rd_valid <= 1'b0;
      wr_ack   <= 1'b0;
      if (rd_req) begin
         if (rwait >= lat) begin
            rd_valid <= 1'b1;
            rd_data  <= ~rd_addr;
            rwait = 0;
         end else rwait++;
      end
      if (wr_req) begin
         if (wwait >= lat) begin
            wr_ack <= 1'b1;
            if (nw < 64) begin
               wa[nw] = wr_addr;
               wd[nw] = wr_data;
               ws[nw] = wr_word;
            end
            last_wa = wr_addr;
            nw++;
            wwait = 0;
         end else wwait++;
      end
      if (irq_o) nirq++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input int which, input logic [31:0] v);
      @(negedge clk);
      case (which)
         0: begin src_we = 1; src_wdata = v; end
         1: begin dst_we = 1; dst_wdata = v; end
         2: begin cnt_we = 1; cnt_wdata = v[CNT_W-1:0]; end
         default: begin ctl_we = 1; ctl_wdata = v[15:0]; end
      endcase
      @(negedge clk);
      src_we = 0; dst_we = 0; cnt_we = 0; ctl_we = 0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: hblank_i = 1;
         1: vblank_i = 1;
         default: fifo_req_i = 1;
      endcase
      @(negedge clk);
      hblank_i = 0; vblank_i = 0; fifo_req_i = 0;
   endtask

   task automatic settle();
      int n = 0;
      @(negedge clk);
      while (busy_o && n < 150000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 150000) chk("R11 hung transfer", 1, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic clear_log();
      nw = 0;
      nirq = 0;
   endtask

   function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] m,
                                        input logic w, input logic is_dst);
      logic [31:0] s = w ? 32'd4 : 32'd2;
      case (m)
         2'd0: return a + s;
         2'd1: return a - s;
         2'd2: return a;
         default: return is_dst ? a + s : a;
      endcase
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      logic [31:0] es, ed;
      repeat (3) @(negedge clk);
      // R3/R11: reset state
      chk("R3 reset busy", busy_o, 0);
      chk("R11 reset rd_req", rd_req, 0);
      chk("R11 reset wr_req", wr_req, 0);
      chk("R7 reset irq", irq_o, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R4 reset ctl", ctl_q, 0);
      chk("R3 reset blocking", blocking_o, 1);

      // R1 R5 R6 R7: immediate transfers from the table
      for (int v = 0; v < 6; v++) begin
         clear_log();
         put(0, VECS[v].src);
         put(1, VECS[v].dst);
         put(2, {16'd0, VECS[v].cnt});
         put(3, {16'd0, VECS[v].ctl});
         settle();
         chk("R7 unit count", nw, VECS[v].cnt);
         es = VECS[v].src & SMASK;
         ed = VECS[v].dst & DMASK;
         for (int i = 0; i < int'(VECS[v].cnt); i++) begin
            chk("R1 R5 R6 write address", wa[i], ed);
            chk("R11 write data from read", wd[i], ~es);
            chk("R5 unit size", ws[i], VECS[v].ctl[10]);
            es = step(es, VECS[v].ctl[8:7], VECS[v].ctl[10], 1'b0);
            ed = step(ed, VECS[v].ctl[6:5], VECS[v].ctl[10], 1'b1);
         end
         chk("R7 irq pulses", nirq, VECS[v].ctl[14] ? 1 : 0);
         chk("R7 enable cleared", ctl_q[15], 0);
         chk("R7 busy low", busy_o, 0);
      end

      // R3: blocking follows timing field
      put(3, 32'h1000);
      chk("R3 blocking off", blocking_o, 0);

      // R3 R4: vblank timing, latched source, wrong trigger ignored, slow bus
      lat = 2;
      clear_log();
      put(0, 32'h100); put(1, 32'h200); put(2, 32'd2);
      put(3, 32'h9400);
      put(0, 32'h900);
      repeat (3) @(negedge clk);
      chk("R4 no start before vblank", busy_o, 0);
      pulse(0);
      repeat (3) @(negedge clk);
      chk("R4 hblank ignored", nw, 0);
      pulse(1);
      settle();
      chk("R4 vblank units", nw, 2);
      chk("R3 latched source", wd[0], ~32'h100);
      chk("R11 slow bus second data", wd[1], ~32'h104);
      lat = 0;

      // R4: hblank timing, vblank ignored
      clear_log();
      put(0, 32'h500); put(1, 32'h600); put(2, 32'd1);
      put(3, 32'hA400);
      pulse(1);
      repeat (3) @(negedge clk);
      chk("R4 vblank ignored", nw, 0);
      pulse(0);
      settle();
      chk("R4 hblank units", nw, 1);
      chk("R4 hblank address", wa[0], 32'h600);

      // R6 R8: repeat with destination reload
      clear_log();
      put(0, 32'h1000); put(1, 32'h2000); put(2, 32'd2);
      put(3, 32'hA660);
      pulse(0);
      settle();
      pulse(0);
      settle();
      chk("R8 units over two bursts", nw, 4);
      chk("R6 reload dst first", wa[2], 32'h2000);
      chk("R6 reload dst second", wa[3], 32'h2004);
      chk("R8 source continues", wd[2], ~32'h1008);
      chk("R8 enable kept", ctl_q[15], 1);
      chk("R8 no irq", nirq, 0);
      put(3, 32'h0);

      // R8: repeat without reload keeps the destination running
      clear_log();
      put(3, 32'hA600);
      pulse(0);
      settle();
      pulse(0);
      settle();
      chk("R8 count reloaded", nw, 4);
      chk("R8 dst continues", wa[2], 32'h2008);
      put(3, 32'h0);

      // R9 R10: audio-FIFO requests
      clear_log();
      put(0, 32'h3000); put(1, 32'h0400_00A0); put(2, 32'd7);
      put(3, 32'hB200);
      repeat (2) @(negedge clk);
      chk("R4 audio not immediate", busy_o, 0);
      fifo_addr_i = 32'h0400_00A4;
      pulse(2);
      repeat (3) @(negedge clk);
      chk("R10 wrong fifo ignored", nw, 0);
      fifo_addr_i = 32'h0400_00A0;
      pulse(2);
      settle();
      chk("R10 four units", nw, 4);
      for (int i = 0; i < 4; i++) begin
         chk("R9 fixed dst", wa[i], 32'h0400_00A0);
         chk("R9 word units", ws[i], 1);
         chk("R9 source steps by 4", wd[i], ~(32'h3000 + 32'(4 * i)));
      end
      chk("R9 word bit set", ctl_q[10], 1);
      put(3, 32'h0);
      clear_log();
      put(3, 32'hB000);
      pulse(2);
      repeat (3) @(negedge clk);
      chk("R10 no repeat ignored", nw, 0);
      chk("R10 busy stays low", busy_o, 0);
      put(3, 32'h0);

      // R2: zero count means maximum
      clear_log();
      put(0, 32'h0); put(1, 32'h0); put(2, 32'd0);
      put(3, 32'h8400);
      settle();
      chk("R2 zero count units", nw, 16383);
      chk("R2 last address", last_wa, 32'h0000_FFF8);
      chk("R7 no irq without enable", nirq, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule